// File: doc/BRIEF.md
# Prefixed Register-Command Decoder

This block sits on the receive side of a display controller and turns a byte stream into register updates. Each command opens with a sync byte of 0xAF and an opcode byte. A register-set command carries an index byte and a value byte and updates one byte-wide register. A copy command carries seven operand bytes, which the decoder reads and drops without moving any pixels. Any other opcode raises a one-cycle error pulse, and the parser then searches for the next sync byte.

A special index works as a lock for the video registers. While the lock is held, writes land only in a shadow bank. When the lock is released, the whole shadow bank moves into the active bank on one clock edge, so the display timing changes in one step. The block decodes a few multi-byte fields from the active bank. The frame base addresses are most-significant byte first, the horizontal active width is big-endian and the pixel-clock divisor is little-endian. The block also outputs the blank mode and the colour-depth selector.

The parser has five named states. It starts in HUNT. HUNT goes to OPCODE on a sync byte. OPCODE stays in OPCODE on another sync byte, goes to INDEX on opcode 0x20, goes to COPY on opcode 0x6A, and returns to HUNT on any other opcode. INDEX goes to VALUE on the next byte. VALUE goes back to HUNT on the next byte and writes the register. COPY goes back to HUNT after its seventh operand byte.

Top module: `regcmd_decoder`

## Requirements
- R1: In HUNT, every accepted byte other than 0xAF is dropped and changes no register.
- R2: The sequence 0xAF, 0x20, index, value writes value to register index when index is below NUM_REGS. When unlocked, the new value appears on reg_flat (byte index at bits index*8+7:index*8) in the cycle after the value byte is accepted. An index at or above NUM_REGS, other than 0xFF, changes nothing.
- R3: Writing 0x00 to index 0xFF sets locked and writing 0xFF to index 0xFF clears it. Any other value written to index 0xFF leaves the lock and all registers unchanged.
- R4: While locked, register writes leave reg_flat unchanged.
- R5: On the cycle after an unlock is accepted, reg_flat holds every value written during the lock.
- R6: After 0xAF 0x6A, the next seven accepted bytes are consumed, including any 0xAF among them, and change no register. The byte after them is parsed from HUNT.
- R7: An opcode other than 0x20, 0x6A or 0xAF raises bad_opcode for exactly the following cycle. Bytes after it are then ignored until the next 0xAF.
- R8: A 0xAF in the opcode position is padding. The parser stays ready for an opcode, so 0xAF 0xAF 0x20 index value performs the write.
- R9: base16_addr is {reg 0x20, reg 0x21, reg 0x22} and base8_addr is {reg 0x26, reg 0x27, reg 0x28}, with the lower index as the most significant byte.
- R10: blank_mode shows active register 0x1F (0x00 both syncs on, 0x01 blanked but powered, 0x05 standby, 0x07 power-down) and depth_sel shows active register 0x00 (0 selects 16 bits per pixel).
- R11: h_active is {reg 0x0F, reg 0x10} (big-endian) and pclk_div5k is {reg 0x1C, reg 0x1B} (little-endian).
- R12: After reset the block is unlocked, bad_opcode is low, all registers are zero and blank_mode is 0x07.
- R13: in_ready is always high. A cycle with in_valid low changes no state, even within a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on in_byte is offered |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Always high; a byte is taken whenever in_valid is high |
| locked | output | 1 | Video-register lock held |
| bad_opcode | output | 1 | One-cycle pulse after an unknown opcode |
| reg_flat | output | NUM_REGS*8 | Active register bank, index i at bits i*8+7:i*8 |
| blank_mode | output | 8 | Active blank-mode register |
| depth_sel | output | 8 | Active colour-depth selector |
| base16_addr | output | 24 | 16bpp frame base address |
| base8_addr | output | 24 | 8bpp frame base address |
| h_active | output | 16 | Horizontal active pixels (big-endian pair) |
| pclk_div5k | output | 16 | Pixel clock in 5 kHz units (little-endian pair) |

## Verification
The assertions check several properties on every cycle. The active bank stays frozen across locked cycles and across cycles with no valid byte. The error pulse never lasts two cycles. Outside the lock, shadow and active banks agree, and when the lock falls the active bank matches the shadow bank. Parsing matters, such as copy operands that contain the sync byte, padding sync bytes, resynchronisation after a bad opcode and the byte order of each field. Only the bench scenarios can show these, by comparing against a behavioural reference model on every clock.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
    localparam logic [7:0] SYNC_BYTE   = 8'hAF;
    localparam logic [7:0] OP_SET      = 8'h20;
    localparam logic [7:0] OP_COPY     = 8'h6A;
    localparam logic [7:0] LOCK_IDX    = 8'hFF;
    localparam logic [7:0] LOCK_VAL    = 8'h00;
    localparam logic [7:0] UNLOCK_VAL  = 8'hFF;

    localparam int IDX_DEPTH   = 8'h00;
    localparam int IDX_HACT_HI = 8'h0F;
    localparam int IDX_HACT_LO = 8'h10;
    localparam int IDX_PCLK_LO = 8'h1B;
    localparam int IDX_PCLK_HI = 8'h1C;
    localparam int IDX_BLANK   = 8'h1F;
    localparam int IDX_B16     = 8'h20;
    localparam int IDX_B8      = 8'h26;

    localparam logic [7:0] BLANK_RESET = 8'h07;

    typedef enum logic [2:0] {
        S_HUNT,
        S_OPCODE,
        S_INDEX,
        S_VALUE,
        S_COPY
    } parse_state_t;
endpackage

// File: rtl/regcmd_parser.sv
module regcmd_parser
    import regcmd_pkg::*;
#(
    parameter int COPY_OPERANDS = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_val,
    output logic       bad_op
);
    localparam int CW = $clog2(COPY_OPERANDS + 1);

    parse_state_t   state, nxt;
    logic [7:0]     idx_q;
    logic [CW-1:0]  cnt_q;
    logic           err_q;
    logic           bad_now;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_HUNT;
            idx_q <= 8'h00;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            state <= nxt;
            err_q <= bad_now;
            if (state == S_INDEX && in_valid)
                idx_q <= in_byte;
            if (state == S_OPCODE && in_valid && in_byte == OP_COPY)
                cnt_q <= CW'(COPY_OPERANDS);
            else if (state == S_COPY && in_valid)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        nxt     = state;
        bad_now = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = idx_q;
        wr_val  = in_byte;
        unique case (state)
            S_HUNT: begin
                if (in_valid && in_byte == SYNC_BYTE)
                    nxt = S_OPCODE;
            end
            S_OPCODE: begin
                if (in_valid) begin
                    if (in_byte == SYNC_BYTE)
                        nxt = S_OPCODE;
                    else if (in_byte == OP_SET)
                        nxt = S_INDEX;
                    else if (in_byte == OP_COPY)
                        nxt = S_COPY;
                    else begin
                        bad_now = 1'b1;
                        nxt     = S_HUNT;
                    end
                end
            end
            S_INDEX: begin
                if (in_valid)
                    nxt = S_VALUE;
            end
            S_VALUE: begin
                if (in_valid) begin
                    wr_en = 1'b1;
                    nxt   = S_HUNT;
                end
            end
            S_COPY: begin
                if (in_valid && cnt_q == CW'(1))
                    nxt = S_HUNT;
            end
            default: nxt = S_HUNT;
        endcase
    end

    assign bad_op = err_q;
endmodule

// File: rtl/regcmd_shadow_bank.sv
module regcmd_shadow_bank
    import regcmd_pkg::*;
#(
    parameter int NUM_REGS = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_val,
    output logic                  locked,
    output logic [NUM_REGS*8-1:0] shadow_flat,
    output logic [NUM_REGS*8-1:0] active_flat
);
    logic lock_hit, do_lock, do_unlock, locked_q;

    assign lock_hit  = wr_en && (wr_idx == LOCK_IDX);
    assign do_lock   = lock_hit && (wr_val == LOCK_VAL);
    assign do_unlock = lock_hit && (wr_val == UNLOCK_VAL);

    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b0;
        else if (do_lock)
            locked_q <= 1'b1;
        else if (do_unlock)
            locked_q <= 1'b0;
    end

    assign locked = locked_q;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] RST_VAL = (i == IDX_BLANK) ? BLANK_RESET : 8'h00;
        logic [7:0] sh_q, ac_q;
        logic       hit;

        assign hit = wr_en && (wr_idx == 8'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= RST_VAL;
                ac_q <= RST_VAL;
            end else begin
                if (hit)
                    sh_q <= wr_val;
                if (hit && !locked_q)
                    ac_q <= wr_val;
                else if (do_unlock)
                    ac_q <= sh_q;
            end
        end

        assign shadow_flat[i*8 +: 8] = sh_q;
        assign active_flat[i*8 +: 8] = ac_q;
    end
endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
    import regcmd_pkg::*;
#(
    parameter int NUM_REGS      = 48,
    parameter int COPY_OPERANDS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    output logic                  in_ready,
    output logic                  locked,
    output logic                  bad_opcode,
    output logic [NUM_REGS*8-1:0] reg_flat,
    output logic [7:0]            blank_mode,
    output logic [7:0]            depth_sel,
    output logic [23:0]           base16_addr,
    output logic [23:0]           base8_addr,
    output logic [15:0]           h_active,
    output logic [15:0]           pclk_div5k
);
    logic                  wr_en;
    logic [7:0]            wr_idx, wr_val;
    logic [NUM_REGS*8-1:0] shadow_flat;

    regcmd_parser #(.COPY_OPERANDS(COPY_OPERANDS)) u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .bad_op   (bad_opcode)
    );

    regcmd_shadow_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_val      (wr_val),
        .locked      (locked),
        .shadow_flat (shadow_flat),
        .active_flat (reg_flat)
    );

    assign in_ready    = 1'b1;
    assign blank_mode  = reg_flat[IDX_BLANK*8 +: 8];
    assign depth_sel   = reg_flat[IDX_DEPTH*8 +: 8];
    assign base16_addr = {reg_flat[IDX_B16*8 +: 8], reg_flat[(IDX_B16+1)*8 +: 8],
                          reg_flat[(IDX_B16+2)*8 +: 8]};
    assign base8_addr  = {reg_flat[IDX_B8*8 +: 8], reg_flat[(IDX_B8+1)*8 +: 8],
                          reg_flat[(IDX_B8+2)*8 +: 8]};
    assign h_active    = {reg_flat[IDX_HACT_HI*8 +: 8], reg_flat[IDX_HACT_LO*8 +: 8]};
    assign pclk_div5k  = {reg_flat[IDX_PCLK_HI*8 +: 8], reg_flat[IDX_PCLK_LO*8 +: 8]};
endmodule

// File: rtl/regcmd_checker.sv
module regcmd_checker #(
    parameter int NUM_REGS = 48
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  locked,
    input logic                  bad_opcode,
    input logic [NUM_REGS*8-1:0] active_flat,
    input logic [NUM_REGS*8-1:0] shadow_flat
);
    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_opcode |=> !bad_opcode);

    p_lock_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(active_flat));

    p_unlock_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> (active_flat == shadow_flat));

    p_banks_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !$past(locked)) |-> (active_flat == shadow_flat));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(active_flat) && !bad_opcode));
endmodule

bind regcmd_decoder regcmd_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .locked      (locked),
    .bad_opcode  (bad_opcode),
    .active_flat (reg_flat),
    .shadow_flat (u_bank.shadow_flat)
);

// File: tb/regcmd_decoder_bench.sv
module regcmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_REGS   = 48;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [7:0]            in_byte = 8'h00;
    logic                  in_ready, locked, bad_opcode;
    logic [NUM_REGS*8-1:0] reg_flat;
    logic [7:0]            blank_mode, depth_sel;
    logic [23:0]           base16_addr, base8_addr;
    logic [15:0]           h_active, pclk_div5k;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_sh [NUM_REGS];
    logic [7:0] m_ac [NUM_REGS];
    bit  m_lock;
    bit  m_err;
    int  m_state;   // 0 hunt,1 opcode,2 index,3 value,4 copy
    int  m_idx;
    int  m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    regcmd_decoder #(.NUM_REGS(NUM_REGS)) u_regcmd_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .locked(locked), .bad_opcode(bad_opcode),
        .reg_flat(reg_flat), .blank_mode(blank_mode), .depth_sel(depth_sel),
        .base16_addr(base16_addr), .base8_addr(base8_addr),
        .h_active(h_active), .pclk_div5k(pclk_div5k)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NUM_REGS; i++) begin
            m_sh[i] = (i == 8'h1F) ? 8'h07 : 8'h00;
            m_ac[i] = m_sh[i];
        end
        m_lock = 0; m_err = 0; m_state = 0; m_idx = 0; m_cnt = 0;
    endtask

    task automatic model_step(input bit v, input logic [7:0] b);
        bit e = 0;
        if (v) begin
            case (m_state)
                0: if (b == 8'hAF) m_state = 1;
                1: begin
                    if (b == 8'hAF) m_state = 1;
                    else if (b == 8'h20) m_state = 2;
                    else if (b == 8'h6A) begin m_state = 4; m_cnt = 7; end
                    else begin e = 1; m_state = 0; end
                end
                2: begin m_idx = b; m_state = 3; end
                3: begin
                    if (m_idx == 8'hFF) begin
                        if (b == 8'h00) m_lock = 1;
                        else if (b == 8'hFF) begin
                            m_lock = 0;
                            for (int i = 0; i < NUM_REGS; i++) m_ac[i] = m_sh[i];
                        end
                    end else if (m_idx < NUM_REGS) begin
                        m_sh[m_idx] = b;
                        if (!m_lock) m_ac[m_idx] = b;
                    end
                    m_state = 0;
                end
                default: begin
                    m_cnt--;
                    if (m_cnt == 0) m_state = 0;
                end
            endcase
        end
        m_err = e;
    endtask

    function automatic logic [7:0] dut_reg(input int idx);
        return reg_flat[idx*8 +: 8];
    endfunction

    task automatic compare_all();
        logic [NUM_REGS*8-1:0] exp_flat;
        for (int i = 0; i < NUM_REGS; i++) exp_flat[i*8 +: 8] = m_ac[i];
        vectors++;
        if (reg_flat !== exp_flat) begin
            miscompares++;
            $display("FAIL R2 reg_flat got=%h exp=%h at %0t", reg_flat, exp_flat, $time);
        end
        check("R3 locked", 32'(locked), 32'(m_lock));
        check("R7 bad_opcode", 32'(bad_opcode), 32'(m_err));
        check("R10 blank_mode", 32'(blank_mode), 32'(m_ac[8'h1F]));
        check("R10 depth_sel", 32'(depth_sel), 32'(m_ac[0]));
        check("R9 base16", 32'(base16_addr), {8'h0, m_ac[8'h20], m_ac[8'h21], m_ac[8'h22]});
        check("R9 base8", 32'(base8_addr), {8'h0, m_ac[8'h26], m_ac[8'h27], m_ac[8'h28]});
        check("R11 h_active", 32'(h_active), {16'h0, m_ac[8'h0F], m_ac[8'h10]});
        check("R11 pclk", 32'(pclk_div5k), {16'h0, m_ac[8'h1C], m_ac[8'h1B]});
        check("R13 in_ready", 32'(in_ready), 32'd1);
    endtask

    // inputs change at negedge; results compared at the following negedge
    task automatic step(input bit v, input logic [7:0] b);
        in_valid = v;
        in_byte  = b;
        model_step(v, b);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic put(input logic [7:0] b);
        step(1'b1, b);
    endtask

    task automatic idle(input int n, input logic [7:0] junk);
        for (int i = 0; i < n; i++) step(1'b0, junk);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] val);
        put(8'hAF); put(8'h20); put(idx); put(val);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R13 watchdog expired got=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        compare_all();
        check("R12 blank after reset", 32'(blank_mode), 32'h07);
        check("R12 unlocked after reset", 32'(locked), 32'd0);
        check("R12 reg zero after reset", 32'(dut_reg(5)), 32'd0);

        // R13: sync byte with valid low is not taken; R1: stray bytes ignored
        idle(2, 8'hAF);
        put(8'h20); put(8'h05); put(8'h11);
        check("R1 stray bytes ignored", 32'(dut_reg(5)), 32'h00);

        // R2/R10: unlocked write seen next cycle
        wr(8'h1F, 8'h00);
        check("R2 R10 blank on", 32'(blank_mode), 32'h00);

        // R9: base addresses, MSB at lower index
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
        wr(8'h26, 8'h9A); wr(8'h27, 8'hBC); wr(8'h28, 8'hDE);
        check("R9 base16", 32'(base16_addr), 32'h123456);
        check("R9 base8", 32'(base8_addr), 32'h9ABCDE);

        // R11: byte orders
        wr(8'h0F, 8'h05); wr(8'h10, 8'h00);
        wr(8'h1B, 8'h4C); wr(8'h1C, 8'h1D);
        check("R11 h_active big-endian", 32'(h_active), 32'h0500);
        check("R11 pclk little-endian", 32'(pclk_div5k), 32'h1D4C);

        // R3/R4/R5: lock staging
        wr(8'hFF, 8'h00);
        check("R3 lock set", 32'(locked), 32'd1);
        wr(8'h1F, 8'h07);
        wr(8'h00, 8'h01);
        wr(8'h21, 8'hEE);
        check("R4 blank frozen", 32'(blank_mode), 32'h00);
        check("R4 depth frozen", 32'(depth_sel), 32'h00);
        wr(8'hFF, 8'h55);
        check("R3 other value keeps lock", 32'(locked), 32'd1);
        wr(8'hFF, 8'hFF);
        check("R5 lock cleared", 32'(locked), 32'd0);
        check("R5 blank moved", 32'(blank_mode), 32'h07);
        check("R5 depth moved", 32'(depth_sel), 32'h01);
        check("R5 base16 moved", 32'(base16_addr), 32'h12EE56);

        // R6: copy operands swallowed even when they look like commands
        put(8'hAF); put(8'h6A);
        put(8'hAF); put(8'h20); put(8'h05); put(8'h99);
        put(8'hAF); put(8'h20); put(8'h05);
        check("R6 copy operands ignored", 32'(dut_reg(5)), 32'h00);
        wr(8'h05, 8'h42);
        check("R6 command after copy", 32'(dut_reg(5)), 32'h42);

        // R8: padding sync byte
        put(8'hAF); put(8'hAF); put(8'h20); put(8'h03); put(8'h77);
        check("R8 padding then write", 32'(dut_reg(3)), 32'h77);

        // R7: unknown opcode then resync
        put(8'hAF);
        put(8'h31);
        check("R7 error pulse", 32'(bad_opcode), 32'd1);
        put(8'h20);
        check("R7 error single cycle", 32'(bad_opcode), 32'd0);
        put(8'h04); put(8'h66);
        check("R7 ignored until sync", 32'(dut_reg(4)), 32'h00);
        wr(8'h04, 8'h66);
        check("R7 resync write", 32'(dut_reg(4)), 32'h66);

        // R13: gaps inside a command
        put(8'hAF); idle(1, 8'h00); put(8'h20); idle(2, 8'hAF);
        put(8'h06); idle(1, 8'h31); put(8'h88);
        check("R13 gapped command", 32'(dut_reg(6)), 32'h88);

        // R2: out-of-range index ignored
        wr(8'h40, 8'hAB);
        check("R2 out of range", 32'(dut_reg(NUM_REGS-1)), 32'h00);

        idle(3, 8'h00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule